// File: doc/BRIEF.md
# Multiplexed Display Code Store and Refresher

This block keeps one 8-bit display code per digit in a small RAM and presents the code of the digit being refreshed on two 4-bit output nibbles. A processor-side port writes and reads the RAM through an internal address pointer. The pointer is loaded explicitly and can optionally step forward after every access, so a whole display can be filled with a burst of writes.

The refresh side receives a scan index and a one-cycle advance pulse from an external scan generator. On each pulse the block latches the code for that index. The scan mode limits which RAM locations can be reached: 4, 8 or all 16. Each output nibble can be replaced at once by a programmable blank pattern, independently of the other.

The CPU and scan controls are plain strobes. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `disp_refresh`

## Requirements
- R1: While reset is active, and right after it is released, the address pointer is 0, every RAM word is 0x00, the latched display code is 0x00 and `cpu_rdata` is 0x00.
- R2: `cpu_wr` stores `cpu_wdata` at the pointer's current location. `cpu_addr_load` sets the pointer to `cpu_addr` for the next cycle. A write in the same cycle still uses the pointer value from before the load.
- R3: When `cpu_ainc` is 1 and `cpu_addr_load` is 0, each cycle with `cpu_wr` or `cpu_rd` high advances the pointer by one. After location 15 it wraps to 0.
- R4: When `cpu_ainc` is 0, reads and writes leave the pointer unchanged.
- R5: `cpu_rd` places the word at the pointer on `cpu_rdata` one cycle later. The value is held until the next read. A write in the same cycle is not visible to that read.
- R6: On a `scan_adv` pulse the display code register loads the word at the scan index masked by mode. Mode 0 (decoded) uses `scan_idx[1:0]`, mode 1 (8-digit) uses `scan_idx[2:0]`, and modes 2 and 3 (16-digit) use all four bits. Between pulses the register holds its value.
- R7: Nibble A is bits 7:4 of the latched code and nibble B is bits 3:0.
- R8: `blank_a` high drives `disp_a` to `blank_code_a` in the same cycle without touching `disp_b`. `blank_b` acts on `disp_b` in the same way.
- R9: If `scan_adv` and `cpu_wr` target the same location in one cycle, the display register latches the new `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_load | input | 1 | Load the address pointer from `cpu_addr` |
| cpu_addr | input | 4 | New pointer value |
| cpu_ainc | input | 1 | Step the pointer after each access |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| scan_idx | input | 4 | Digit index from the scan generator |
| scan_adv | input | 1 | Latch the code for `scan_idx` |
| scan_mode | input | 2 | 0 decoded 4-digit, 1 encoded 8-digit, 2/3 encoded 16-digit |
| blank_a | input | 1 | Blank nibble A |
| blank_b | input | 1 | Blank nibble B |
| blank_code_a | input | 4 | Pattern shown on A when blanked |
| blank_code_b | input | 4 | Pattern shown on B when blanked |
| disp_a | output | 4 | Upper display nibble |
| disp_b | output | 4 | Lower display nibble |

## Verification
The bench builds the block with its defaults: 16 digits of 8 bits. With these values the pointer wrap from 15 to 0 and all three mode masks can be reached with short directed bursts. A scan index above 3 or 7 then shows the folding onto the low locations. A long randomized stretch mixes loads, increments, same-cycle read and write, collisions and blanking. Every output is compared against a behavioural model on each cycle.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    SCAN_DEC4   = 2'd0,
    SCAN_ENC8   = 2'd1,
    SCAN_ENC16  = 2'd2,
    SCAN_ENC16B = 2'd3
  } scan_mode_e;

  localparam int DEC_DIGITS = 4;
  localparam int ENC8_DIGITS = 8;
endpackage

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (load)   addr <= load_addr;
    else if (step)   addr <= addr + 1'b1;
  end

  // R3: stepping from the last location lands on zero
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && addr == LAST) |=> (addr == '0));

  // R4: without load or step the pointer stays put
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(addr));
endmodule

// File: rtl/disp_store.sv
module disp_store #(
  parameter int DIGITS = 16,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [WIDTH-1:0]  fetch_word
);
  logic [WIDTH-1:0] mem [DIGITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIGITS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[wr_addr];
  end

  // R9: a write to the location being fetched is forwarded
  always_comb begin
    if (wr_en && wr_addr == fetch_addr) fetch_word = wr_data;
    else                                fetch_word = mem[fetch_addr];
  end

  // R5: read data only changes on a read
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/disp_out.sv
module disp_out #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WIDTH-1:0]   word_in,
  input  logic               blank_a,
  input  logic               blank_b,
  input  logic [WIDTH/2-1:0] code_a,
  input  logic [WIDTH/2-1:0] code_b,
  output logic [WIDTH/2-1:0] out_a,
  output logic [WIDTH/2-1:0] out_b
);
  localparam int NIB = WIDTH / 2;

  logic [WIDTH-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= word_in;
  end

  assign out_a = blank_a ? code_a : code_q[WIDTH-1:NIB];
  assign out_b = blank_b ? code_b : code_q[NIB-1:0];

  // R6: the latched code only moves on an advance pulse
  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code_q));
endmodule

// File: rtl/disp_refresh.sv
module disp_refresh #(
  parameter int DIGITS = 16,
  parameter int WIDTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_addr_load,
  input  logic [$clog2(DIGITS)-1:0]  cpu_addr,
  input  logic                       cpu_ainc,
  input  logic                       cpu_wr,
  input  logic [WIDTH-1:0]           cpu_wdata,
  input  logic                       cpu_rd,
  output logic [WIDTH-1:0]           cpu_rdata,
  input  logic [$clog2(DIGITS)-1:0]  scan_idx,
  input  logic                       scan_adv,
  input  logic [1:0]                 scan_mode,
  input  logic                       blank_a,
  input  logic                       blank_b,
  input  logic [WIDTH/2-1:0]         blank_code_a,
  input  logic [WIDTH/2-1:0]         blank_code_b,
  output logic [WIDTH/2-1:0]         disp_a,
  output logic [WIDTH/2-1:0]         disp_b
);
  import disp_pkg::*;

  localparam int ADDR_W = $clog2(DIGITS);
  localparam int NIB    = WIDTH / 2;
  localparam logic [ADDR_W-1:0] DEC_MASK  = ADDR_W'(DEC_DIGITS - 1);
  localparam logic [ADDR_W-1:0] ENC8_MASK = ADDR_W'(ENC8_DIGITS - 1);

  scan_mode_e        mode;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] fetch_addr;
  logic [WIDTH-1:0]  fetch_word;
  logic              step;

  assign mode = scan_mode_e'(scan_mode);
  assign step = cpu_ainc && (cpu_wr || cpu_rd);

  always_comb begin
    unique case (mode)
      SCAN_DEC4: fetch_addr = scan_idx & DEC_MASK;
      SCAN_ENC8: fetch_addr = scan_idx & ENC8_MASK;
      default:   fetch_addr = scan_idx;
    endcase
  end

  disp_addr_ctr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cpu_addr_load),
    .load_addr (cpu_addr),
    .step      (step),
    .addr      (ptr)
  );

  disp_store #(.DIGITS(DIGITS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cpu_wr),
    .wr_addr    (ptr),
    .wr_data    (cpu_wdata),
    .rd_en      (cpu_rd),
    .rd_data    (cpu_rdata),
    .fetch_addr (fetch_addr),
    .fetch_word (fetch_word)
  );

  disp_out #(.WIDTH(WIDTH)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (scan_adv),
    .word_in (fetch_word),
    .blank_a (blank_a),
    .blank_b (blank_b),
    .code_a  (blank_code_a),
    .code_b  (blank_code_b),
    .out_a   (disp_a),
    .out_b   (disp_b)
  );

  // R9: a colliding write shows up on the unblanked nibbles next cycle
  p_collide_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_adv && cpu_wr && fetch_addr == ptr) |=>
      (blank_a || disp_a == $past(cpu_wdata[WIDTH-1:NIB])));
  p_collide_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_adv && cpu_wr && fetch_addr == ptr) |=>
      (blank_b || disp_b == $past(cpu_wdata[NIB-1:0])));
endmodule

// File: tb/test_disp_refresh.sv
module test_disp_refresh;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_addr_load = 1'b0, cpu_ainc = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0] cpu_addr = '0, scan_idx = '0;
  logic [7:0] cpu_wdata = '0;
  logic       scan_adv = 1'b0, blank_a = 1'b0, blank_b = 1'b0;
  logic [1:0] scan_mode = 2'd2;
  logic [3:0] blank_code_a = '0, blank_code_b = '0;
  logic [7:0] cpu_rdata;
  logic [3:0] disp_a, disp_b;

  int compared = 0, mismatched = 0;
  bit started = 0;

  // reference state
  int m_mem [16];
  int m_ptr = 0, m_rdata = 0, m_code = 0;

  always #5 clk = ~clk;

  disp_refresh i_disp_refresh (.*);

  function automatic int fold(input int idx, input int mode);
    if (mode == 0) return idx % 4;
    if (mode == 1) return idx % 8;
    return idx;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_mem[i] = 0;
      m_ptr = 0; m_rdata = 0; m_code = 0;
    end else begin
      int fa;
      fa = fold(int'(scan_idx), int'(scan_mode));
      if (scan_adv) m_code = (cpu_wr && fa == m_ptr) ? int'(cpu_wdata) : m_mem[fa]; // R6, R9
      if (cpu_rd) m_rdata = m_mem[m_ptr];                                           // R5
      if (cpu_wr) m_mem[m_ptr] = int'(cpu_wdata);                                   // R2
      if (cpu_addr_load) m_ptr = int'(cpu_addr);
      else if (cpu_ainc && (cpu_wr || cpu_rd)) m_ptr = (m_ptr + 1) % 16;            // R3, R4
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      int ea, eb;
      ea = blank_a ? int'(blank_code_a) : (m_code >> 4) & 15;  // R7, R8
      eb = blank_b ? int'(blank_code_b) : m_code & 15;
      check(rst_n ? "R5 cpu_rdata" : "R1 reset cpu_rdata", int'(cpu_rdata), m_rdata);
      check(rst_n ? "R7/R8 disp_a" : "R1 reset disp_a", int'(disp_a), ea);
      check(rst_n ? "R7/R8 disp_b" : "R1 reset disp_b", int'(disp_b), eb);
    end
  end

  task automatic idle();
    cpu_addr_load = 0; cpu_wr = 0; cpu_rd = 0; scan_adv = 0;
  endtask

  task automatic step_cycle();
    @(posedge clk); #2;
  endtask

  task automatic set_ptr(input int a);
    idle(); cpu_addr_load = 1; cpu_addr = 4'(a); step_cycle(); idle();
  endtask

  task automatic write(input int d, input bit inc);
    idle(); cpu_ainc = inc; cpu_wr = 1; cpu_wdata = 8'(d); step_cycle(); idle();
  endtask

  task automatic read(input bit inc);
    idle(); cpu_ainc = inc; cpu_rd = 1; step_cycle(); idle();
  endtask

  task automatic scan(input int idx, input int mode);
    idle(); scan_mode = 2'(mode); scan_idx = 4'(idx); scan_adv = 1; step_cycle(); idle();
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;                                   // R1 checked while low
    step_cycle();
    // R3 wrap on burst writes starting at 14
    set_ptr(14);
    for (int i = 0; i < 4; i++) write(8'hA0 + i, 1);
    // R2 fill every location with distinct codes
    set_ptr(0);
    for (int i = 0; i < 16; i++) write(i * 17 ^ 8'h5C, 1);
    // R4 read without increment twice, R5 read data
    set_ptr(9); read(0); read(0); step_cycle();
    // R5 burst read with increment
    set_ptr(13); for (int i = 0; i < 5; i++) read(1);
    // R6 every mode and index, R7 nibble split
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 16; i++) begin scan(i, m); step_cycle(); end
    // R8 blanking each nibble alone and together
    scan(6, 2);
    blank_code_a = 4'hE; blank_code_b = 4'h3;
    blank_a = 1; step_cycle(); blank_b = 1; step_cycle();
    blank_a = 0; step_cycle(); blank_b = 0; step_cycle();
    // R9 collision of write and fetch
    set_ptr(5);
    idle(); cpu_wr = 1; cpu_wdata = 8'h96; scan_mode = 2; scan_idx = 5; scan_adv = 1;
    step_cycle(); idle(); step_cycle();
    // R2 load with write in same cycle
    set_ptr(2);
    idle(); cpu_addr_load = 1; cpu_addr = 4'd11; cpu_wr = 1; cpu_wdata = 8'h3C; step_cycle(); idle();
    read(0); scan(2, 0); step_cycle();
    // R5 same-cycle read and write
    idle(); cpu_rd = 1; cpu_wr = 1; cpu_wdata = 8'hC3; step_cycle(); idle(); step_cycle();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      cpu_addr_load = ($urandom % 8) == 0;
      cpu_addr      = 4'($urandom);
      cpu_ainc      = 1'($urandom);
      cpu_wr        = ($urandom % 3) == 0;
      cpu_rd        = ($urandom % 3) == 0;
      cpu_wdata     = 8'($urandom);
      scan_adv      = 1'($urandom);
      scan_idx      = 4'($urandom);
      scan_mode     = 2'($urandom);
      blank_a       = ($urandom % 5) == 0;
      blank_b       = ($urandom % 5) == 0;
      blank_code_a  = 4'($urandom);
      blank_code_b  = 4'($urandom);
      step_cycle();
    end
    idle(); blank_a = 0; blank_b = 0;
    step_cycle(); step_cycle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule